// File: doc/BRIEF.md
# Packed Lane Multiply-Low Unit

This execution unit takes two 256-bit vector operands, splits each into eight signed 32-bit lanes, and multiplies each lane pair. From each 64-bit product it keeps only the least significant 32 bits and writes them back into the matching lane of the result. A 2-bit width selector does two things. It sets how many lanes are computed. It also sets how the upper half of the result (bits 255:128) is formed: carried over from the previous destination value, cleared, or filled with products. The fourth code of the selector is illegal. For that code the unit raises a fault, withholds the write enable and returns the previous destination unchanged.

Operations enter through a valid/ready handshake and leave through a second one. A two-stage pipeline sits between them. The first stage holds the operands. The second stage holds the merged result. When the output is not taken, the stall reaches back to the input, so no result is lost or issued twice.

Top module: `vmul_lowpack`

## Requirements
- R1: Each result lane i (bits 32i+31:32i) equals the low 32 bits of the signed product of the matching lanes of srcA and srcB. Overflow is truncated silently, and the value is identical to the low 32 bits of the unsigned product.
- R2: With widthSel = 2'b00, lanes 0 to 3 carry products and bits 255:128 of the result equal bits 255:128 of oldDst.
- R3: With widthSel = 2'b01, lanes 0 to 3 carry products and bits 255:128 of the result are zero.
- R4: With widthSel = 2'b10, all eight lanes carry products.
- R5: With widthSel = 2'b11, udFault is 1, wrEn is 0 and the result equals oldDst in full.
- R6: For every legal widthSel code, wrEn is 1 and udFault is 0.
- R7: With outReady held high and an empty pipeline, an operation accepted on one clock edge presents outValid after exactly two edges.
- R8: While outValid is high and outReady is low, outValid stays high and the result stays stable. inReady drops once both stages are full. Results leave in acceptance order, with none lost or duplicated.
- R9: Synchronous active-high rst empties both stages, so outValid is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Operation accepted on this edge if inValid |
| srcA | input | 256 | First vector operand |
| srcB | input | 256 | Second vector operand |
| oldDst | input | 256 | Previous destination value |
| widthSel | input | 2 | 00 legacy 128, 01 extended 128 zeroing, 10 extended 256, 11 illegal |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes result on this edge |
| result | output | 256 | Merged result vector |
| wrEn | output | 1 | Destination write allowed |
| udFault | output | 1 | Illegal width fault |

## Verification
The embedded assertions take for granted that srcA, srcB, oldDst and widthSel carry known values on every edge where inValid is high. They also assume that reset is held across at least one edge before the first operation. The stimulus meets both conditions by always driving defined data, including idle cycles, where the previous or random values stay in place. It holds rst for several edges at start-up and again in the mid-flight reset test.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
  typedef enum logic [1:0] {
    MODE_LEG128 = 2'b00,
    MODE_EXT128 = 2'b01,
    MODE_EXT256 = 2'b10,
    MODE_BAD    = 2'b11
  } vlen_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cap1;  // load stage-1 operand registers
    logic cap2;  // load stage-2 result registers
  } pipe_strobe_t;
endpackage

// File: rtl/vmul_ctrl.sv
module vmul_ctrl
  import vmul_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output logic         inReady,
  output logic         outValid,
  input  logic         outReady,
  output pipe_strobe_t strobe
);
  logic s1Valid;
  logic s2Valid;
  logic adv1;
  logic adv2;

  always_comb begin
    adv2        = !s2Valid || outReady;
    adv1        = !s1Valid || adv2;
    strobe.cap1 = adv1 && inValid;
    strobe.cap2 = adv2 && s1Valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      if (adv1) s1Valid <= inValid;
      if (adv2) s2Valid <= s1Valid;
    end
  end

  assign inReady  = adv1;
  assign outValid = s2Valid;

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid);  // R8
  AST_STAGE1_KEPT: assert property (@(posedge clk) disable iff (rst)
    s1Valid && !adv2 |=> s1Valid);  // R8
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady |=> s1Valid);  // R7
endmodule

// File: rtl/vmul_dp.sv
module vmul_dp
  import vmul_pkg::*;
#(
  parameter int LANE_W    = 32,
  parameter int NUM_LANES = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  pipe_strobe_t                  strobe,
  input  logic [LANE_W*NUM_LANES-1:0]   srcA,
  input  logic [LANE_W*NUM_LANES-1:0]   srcB,
  input  logic [LANE_W*NUM_LANES-1:0]   oldDst,
  input  logic [1:0]                    widthSel,
  output logic [LANE_W*NUM_LANES-1:0]   result,
  output logic                          wrEn,
  output logic                          udFault
);
  localparam int VEC_W     = LANE_W * NUM_LANES;
  localparam int HALF_LN   = NUM_LANES / 2;
  localparam int HALF_BITS = HALF_LN * LANE_W;

  logic [VEC_W-1:0] s1A;
  logic [VEC_W-1:0] s1B;
  logic [VEC_W-1:0] s1Old;
  vlen_mode_e       s1Mode;
  logic [VEC_W-1:0] merged;

  // stage 1: operand capture (data needs no reset, valid lives in control)
  always_ff @(posedge clk) begin
    if (strobe.cap1) begin
      s1A    <= srcA;
      s1B    <= srcB;
      s1Old  <= oldDst;
      s1Mode <= vlen_mode_e'(widthSel);
    end
  end

  // lane products: a lane-width signed multiply yields the low half directly
  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
    logic signed [LANE_W-1:0] opA;
    logic signed [LANE_W-1:0] opB;
    logic        [LANE_W-1:0] prodLo;
    logic        [LANE_W-1:0] oldLane;
    assign opA     = s1A[gi*LANE_W +: LANE_W];
    assign opB     = s1B[gi*LANE_W +: LANE_W];
    assign prodLo  = opA * opB;
    assign oldLane = s1Old[gi*LANE_W +: LANE_W];

    if (gi < HALF_LN) begin : g_low
      assign merged[gi*LANE_W +: LANE_W] = (s1Mode == MODE_BAD) ? oldLane : prodLo;
    end else begin : g_high
      always_comb begin
        unique case (s1Mode)
          MODE_EXT256: merged[gi*LANE_W +: LANE_W] = prodLo;
          MODE_EXT128: merged[gi*LANE_W +: LANE_W] = '0;
          default:     merged[gi*LANE_W +: LANE_W] = oldLane;
        endcase
      end
    end
  end

  // stage 2: merged result and write qualifiers
  always_ff @(posedge clk) begin
    if (strobe.cap2) begin
      result  <= merged;
      wrEn    <= (s1Mode != MODE_BAD);
      udFault <= (s1Mode == MODE_BAD);
    end
  end

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    strobe.cap2 && s1Mode == MODE_LEG128 |=>
      result[VEC_W-1:HALF_BITS] == $past(s1Old[VEC_W-1:HALF_BITS]));  // R2
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    strobe.cap2 && s1Mode == MODE_EXT128 |=> result[VEC_W-1:HALF_BITS] == '0);  // R3
  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    strobe.cap2 && s1Mode == MODE_BAD |=> udFault && !wrEn && result == $past(s1Old));  // R5
  AST_LEGAL_WRITE: assert property (@(posedge clk) disable iff (rst)
    strobe.cap2 && s1Mode != MODE_BAD |=> wrEn && !udFault);  // R6
endmodule

// File: rtl/vmul_lowpack.sv
module vmul_lowpack
  import vmul_pkg::*;
#(
  parameter int LANE_W    = 32,
  parameter int NUM_LANES = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic [LANE_W*NUM_LANES-1:0] srcA,
  input  logic [LANE_W*NUM_LANES-1:0] srcB,
  input  logic [LANE_W*NUM_LANES-1:0] oldDst,
  input  logic [1:0]                  widthSel,
  output logic                        outValid,
  input  logic                        outReady,
  output logic [LANE_W*NUM_LANES-1:0] result,
  output logic                        wrEn,
  output logic                        udFault
);
  pipe_strobe_t strobe;

  vmul_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );

  vmul_dp #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .srcA     (srcA),
    .srcB     (srcB),
    .oldDst   (oldDst),
    .widthSel (widthSel),
    .result   (result),
    .wrEn     (wrEn),
    .udFault  (udFault)
  );
endmodule

// File: tb/test_vmul_lowpack.sv
module test_vmul_lowpack;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [255:0] srcA = '0;
  logic [255:0] srcB = '0;
  logic [255:0] oldDst = '0;
  logic [1:0]   widthSel = 2'b00;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [255:0] result;
  logic         wrEn;
  logic         udFault;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmul_lowpack i_vmul_lowpack (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .srcA(srcA), .srcB(srcB), .oldDst(oldDst), .widthSel(widthSel),
    .outValid(outValid), .outReady(outReady), .result(result),
    .wrEn(wrEn), .udFault(udFault)
  );

  typedef struct {
    logic [255:0] res;
    logic         we;
    logic         uf;
    logic [1:0]   mode;
    logic [31:0]  lane0;
    logic         hasLane0;
    logic         chkLat;
    int           cyc;
  } exp_t;

  exp_t         sb[$];
  logic         holdPend = 1'b0;
  logic [255:0] heldRes;

  // table: {a lane0, b, mode, hand-computed low product of lane 0}
  localparam logic [97:0] VEC [0:10] = '{
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 32'h0000_0001},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b01, 32'h0000_0001},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b10, 32'h0000_0001},
    {32'h7FFF_FFFF, 32'h0000_0002, 2'b10, 32'hFFFF_FFFE},
    {32'h8000_0000, 32'h8000_0000, 2'b00, 32'h0000_0000},
    {32'h8000_0000, 32'h8000_0000, 2'b10, 32'h0000_0000},
    {32'h0000_FFFF, 32'h0000_FFFF, 2'b01, 32'hFFFE_0001},
    {32'h0001_0001, 32'h0001_0001, 2'b00, 32'h0002_0001},
    {32'h0000_0003, 32'hFFFF_FFFB, 2'b10, 32'hFFFF_FFF1},
    {32'h0000_0000, 32'hDEAD_BEEF, 2'b01, 32'h0000_0000},
    {32'h1234_5678, 32'h9ABC_DEF0, 2'b11, 32'h0000_0000}
  };

  function automatic string reqOf(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  // reference built from unsigned products (R1)
  function automatic logic [255:0] model(input logic [255:0] a, input logic [255:0] b,
                                         input logic [255:0] old, input logic [1:0] m);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [63:0] p;
      p = {32'b0, a[i*32 +: 32]} * {32'b0, b[i*32 +: 32]};
      if (m == 2'b11)               r[i*32 +: 32] = old[i*32 +: 32];
      else if (i < 4 || m == 2'b10) r[i*32 +: 32] = p[31:0];
      else if (m == 2'b01)          r[i*32 +: 32] = 32'h0;
      else                          r[i*32 +: 32] = old[i*32 +: 32];
    end
    return r;
  endfunction

  function automatic logic [255:0] rand256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [255:0] act,
                     input logic [255:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(input logic v, input logic [255:0] a, input logic [255:0] b,
                      input logic [255:0] old, input logic [1:0] m, input logic rdy,
                      input logic [31:0] l0, input logic hasL0, input logic lat);
    @(negedge clk);
    inValid = v; srcA = a; srcB = b; oldDst = old; widthSel = m; outReady = rdy;
    #1;
    cyc++;
    if (holdPend) begin
      chk(outValid == 1'b1, "R8", {255'b0, outValid}, 256'd1);
      chk(result == heldRes, "R8", result, heldRes);
      holdPend = 1'b0;
    end
    if (outValid && outReady) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R8", 256'd0, 256'd1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(result == e.res, reqOf(e.mode), result, e.res);
        chk(wrEn == e.we, e.mode == 2'b11 ? "R5" : "R6", {255'b0, wrEn}, {255'b0, e.we});
        chk(udFault == e.uf, e.mode == 2'b11 ? "R5" : "R6", {255'b0, udFault}, {255'b0, e.uf});
        if (e.hasLane0)
          chk(result[31:0] == e.lane0, "R1", {224'b0, result[31:0]}, {224'b0, e.lane0});
        if (e.chkLat)
          chk(cyc - e.cyc == 2, "R7", 256'(cyc - e.cyc), 256'd2);
      end
    end else if (outValid) begin
      holdPend = 1'b1;
      heldRes  = result;
    end
    if (inValid && inReady) begin
      exp_t n;
      n.res = model(a, b, old, m);
      n.we = (m != 2'b11); n.uf = (m == 2'b11); n.mode = m;
      n.lane0 = l0; n.hasLane0 = hasL0; n.chkLat = lat; n.cyc = cyc;
      sb.push_back(n);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [255:0] oldPat;
    for (int i = 0; i < 8; i++) oldPat[i*32 +: 32] = 32'hA5A5_0000 | i;

    // reset state (R9)
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(outValid == 1'b0, "R9", {255'b0, outValid}, 256'd0);
    chk(inReady == 1'b1, "R9", {255'b0, inReady}, 256'd1);

    // table walk, each vector isolated so latency is checked (R1-R7)
    for (int k = 0; k < 11; k++) begin
      logic [255:0] a, b;
      for (int i = 0; i < 8; i++) begin
        a[i*32 +: 32] = VEC[k][97:66] + i;
        b[i*32 +: 32] = VEC[k][65:34];
      end
      step(1'b1, a, b, oldPat, VEC[k][33:32], 1'b1, VEC[k][31:0], VEC[k][33:32] != 2'b11, 1'b1);
      step(1'b0, a, b, oldPat, VEC[k][33:32], 1'b1, 32'h0, 1'b0, 1'b0);
      step(1'b0, a, b, oldPat, VEC[k][33:32], 1'b1, 32'h0, 1'b0, 1'b0);
    end

    // random stream with random backpressure (R1-R6, R8)
    for (int k = 0; k < 400; k++) begin
      step(($urandom % 4) != 0, rand256(), rand256(), rand256(), 2'($urandom),
           ($urandom % 3) != 0, 32'h0, 1'b0, 1'b0);
    end
    for (int k = 0; k < 4; k++) step(1'b0, '0, '0, '0, 2'b00, 1'b1, 32'h0, 1'b0, 1'b0);

    // full stall: inReady must fall when both stages hold data (R8)
    for (int k = 0; k < 3; k++)
      step(1'b1, rand256(), rand256(), oldPat, 2'b10, 1'b0, 32'h0, 1'b0, 1'b0);
    chk(inReady == 1'b0, "R8", {255'b0, inReady}, 256'd0);
    for (int k = 0; k < 6; k++) step(1'b0, '0, '0, '0, 2'b00, 1'b1, 32'h0, 1'b0, 1'b0);
    chk(sb.size() == 0, "R8", 256'(sb.size()), 256'd0);

    // reset with work in flight (R9)
    step(1'b1, rand256(), rand256(), oldPat, 2'b01, 1'b0, 32'h0, 1'b0, 1'b0);
    step(1'b1, rand256(), rand256(), oldPat, 2'b01, 1'b0, 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    inValid = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(outValid == 1'b0, "R9", {255'b0, outValid}, 256'd0);
    sb.delete();
    holdPend = 1'b0;
    for (int k = 0; k < 3; k++) step(1'b0, '0, '0, '0, 2'b00, 1'b1, 32'h0, 1'b0, 1'b0);
    chk(outValid == 1'b0, "R9", {255'b0, outValid}, 256'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule